// File: doc/BRIEF.md
# Bridge Fault Shutdown Policy Controller

This block decides whether the output stage of a half-bridge or full-bridge may switch. Overcurrent, overtemperature and desaturation flags are first brought into the clock domain. The undervoltage comparator pair feeds a hysteresis tracker. All of these are merged into a single force-safe line shared by every leg. PWM logic downstream gates its outputs with that line, so a high level means that every switch is held off, whatever the modulator is asking for.

Once a trip has happened, a policy state machine decides what comes next. In latch mode the stage stays off until an explicit clear is given. In auto-retry mode the stage waits out a programmable cooldown and then re-enables, but only while no trip source is still present. The number of retries is bounded, and the retry count is forgotten only after a programmable fault-free interval. After reset the outputs stay disabled until the firmware-ready flag has been held high for a fixed number of cycles and the supply has been proven good. The first source that trips is recorded as a fault code.

Top module: `bridge_trip_ctrl`

## Requirements
- R1: A high overcurrent or overtemperature flag drives force_safe_o high after exactly SYNC_STAGES rising clock edges (default 2), and force_safe_o never rises earlier than that.
- R2: A high desaturation flag drives force_safe_o high after a single rising edge when DESAT_FAST is 1. This is the shortest path to the safe state.
- R3: With retry_mode_i = 0, a trip moves state_o to 3 (latched). That state and force_safe_o = 1 persist after the flag drops, until a cycle with clear_i = 1 and no active trip returns state_o to 1 (running).
- R4: With retry_mode_i = 1, a trip while running moves state_o to 2 (cooldown) and increments retry_cnt_o. After cooldown_cfg_i + 1 cycles in that state the block returns to 1 if no trip is active.
- R5: If a trip source is still active when the cooldown expires, the block stays in state 2 with force_safe_o high, and it re-enables only after the source is gone.
- R6: A trip while running with retry_cnt_o equal to or above retry_limit_i moves to state 3 even in auto-retry mode.
- R7: retry_cnt_o returns to 0 after quiet_cfg_i + 1 consecutive running cycles without a trip. clear_i also sets it to 0.
- R8: The undervoltage tracker resets to "low" and is set by a synchronized uv_below_off_i. It is cleared only by a synchronized uv_above_on_i. While it is low, force_safe_o stays high. With neither comparator flag asserted, the previous condition holds.
- R9: After reset state_o = 0 (arming), force_safe_o = 1 and fault_code_o = 0. Arming ends only after the synchronized fw_ready_i has been high for HOLD_CYCLES consecutive edges, with the supply good and no trip. Any low cycle restarts the count.
- R10: fault_code_o captures the first source seen while it reads 0 (4 desaturation, 2 overcurrent, 3 overtemperature, 1 undervoltage crossing while the supply was good, in that priority). It keeps that value until clear_i or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oc_flag_i | input | 1 | Overcurrent / short-circuit flag (asynchronous) |
| ot_flag_i | input | 1 | Overtemperature flag (asynchronous) |
| desat_flag_i | input | 1 | Desaturation trigger (asynchronous) |
| uv_below_off_i | input | 1 | Supply is under the lower undervoltage threshold |
| uv_above_on_i | input | 1 | Supply is over the upper undervoltage threshold |
| fw_ready_i | input | 1 | Firmware reports that it is ready |
| clear_i | input | 1 | Latch clear; also resets the fault code and retry count |
| retry_mode_i | input | 1 | 0 selects latch, 1 selects auto-retry |
| cooldown_cfg_i | input | CW | Cooldown length minus one, in cycles |
| retry_limit_i | input | RW | Maximum number of retries |
| quiet_cfg_i | input | QW | Fault-free running interval minus one that forgets retries |
| force_safe_o | output | 1 | High forces every bridge switch off |
| state_o | output | 2 | 0 arming, 1 running, 2 cooldown, 3 latched |
| retry_cnt_o | output | RW | Retries taken since the last reset of the count |
| fault_code_o | output | 3 | First captured fault source |

## Verification
The bench aims at the following corner cases:
- A one-cycle fault pulse. A design that dropped the safe state together with the flag would re-enable a latched bridge.
- A flag held through the whole cooldown. A design that re-enabled on timer expiry alone would switch into a live short.
- The retry that reaches the limit. An off-by-one design would grant one retry too many, or one too few.
- A long fault-free run followed by two further trips. If the quiet interval never cleared the count, the second of those trips would latch too early.
- The supply sitting between the two undervoltage thresholds. A design without hysteresis would release the outputs there.
- A firmware-ready flag that drops briefly. A design that did not restart the hold count would arm early.

// File: rtl/bridge_trip_pkg.sv
package bridge_trip_pkg;
   typedef enum logic [1:0] {
      ST_ARM   = 2'd0,
      ST_RUN   = 2'd1,
      ST_COOL  = 2'd2,
      ST_LATCH = 2'd3
   } trip_state_t;

   typedef enum logic [2:0] {
      FC_NONE  = 3'd0,
      FC_UV    = 3'd1,
      FC_OC    = 3'd2,
      FC_OT    = 3'd3,
      FC_DESAT = 3'd4
   } fault_code_t;
endpackage

// File: rtl/bridge_trip_sync.sv
module bridge_trip_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("bridge_trip_sync: STAGES must be at least 1");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bridge_trip_uvhyst.sv
module bridge_trip_uvhyst (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic below_off_i,
   input  logic above_on_i,
   output logic supply_low_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          supply_low_o <= 1'b1;
      else if (below_off_i) supply_low_o <= 1'b1;
      else if (above_on_i)  supply_low_o <= 1'b0;
   end
endmodule

// File: rtl/bridge_trip_holdoff.sv
module bridge_trip_holdoff #(
   parameter int unsigned HOLD_CYCLES = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ready_i,
   output logic held_o
);
   localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);
   localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_CYCLES);

   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("bridge_trip_holdoff: HOLD_CYCLES must be at least 1");
   end

   logic [HW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               cnt_q <= '0;
      else if (!ready_i)         cnt_q <= '0;
      else if (cnt_q != HOLD_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign held_o = (cnt_q == HOLD_MAX);
endmodule

// File: rtl/bridge_trip_policy.sv
module bridge_trip_policy
   import bridge_trip_pkg::*;
#(
   parameter int unsigned CW = 8,
   parameter int unsigned RW = 3,
   parameter int unsigned QW = 10
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          trip_i,
   input  logic          supply_low_i,
   input  logic          held_i,
   input  logic          clear_i,
   input  logic          retry_mode_i,
   input  logic [CW-1:0] cooldown_i,
   input  logic [RW-1:0] limit_i,
   input  logic [QW-1:0] quiet_i,
   output trip_state_t   state_o,
   output logic [RW-1:0] retry_cnt_o
);
   trip_state_t   st_q, st_d;
   logic [CW-1:0] cool_q, cool_d;
   logic [QW-1:0] quiet_q, quiet_d;
   logic [RW-1:0] rcnt_q, rcnt_d;

   always_comb begin
      st_d    = st_q;
      cool_d  = cool_q;
      quiet_d = '0;
      rcnt_d  = rcnt_q;
      unique case (st_q)
         ST_ARM: begin
            if (held_i && !trip_i && !supply_low_i) st_d = ST_RUN;
         end
         ST_RUN: begin
            if (trip_i) begin
               if (!retry_mode_i || (rcnt_q >= limit_i)) begin
                  st_d = ST_LATCH;
               end else begin
                  st_d   = ST_COOL;
                  cool_d = '0;
                  rcnt_d = rcnt_q + 1'b1;
               end
            end else if (quiet_q == quiet_i) begin
               rcnt_d = '0;
            end else begin
               quiet_d = quiet_q + 1'b1;
            end
         end
         ST_COOL: begin
            if (cool_q == cooldown_i) begin
               if (!trip_i) st_d = ST_RUN;
            end else begin
               cool_d = cool_q + 1'b1;
            end
         end
         ST_LATCH: begin
            if (clear_i && !trip_i) st_d = ST_RUN;
         end
         default: st_d = ST_LATCH;
      endcase
      if (clear_i) rcnt_d = '0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= ST_ARM;
         cool_q  <= '0;
         quiet_q <= '0;
         rcnt_q  <= '0;
      end else begin
         st_q    <= st_d;
         cool_q  <= cool_d;
         quiet_q <= quiet_d;
         rcnt_q  <= rcnt_d;
      end
   end

   assign state_o     = st_q;
   assign retry_cnt_o = rcnt_q;
endmodule

// File: rtl/bridge_trip_ctrl.sv
module bridge_trip_ctrl
   import bridge_trip_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          DESAT_FAST  = 1'b1,
   parameter int unsigned HOLD_CYCLES = 16,
   parameter int unsigned CW          = 8,
   parameter int unsigned RW          = 3,
   parameter int unsigned QW          = 10
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          oc_flag_i,
   input  logic          ot_flag_i,
   input  logic          desat_flag_i,
   input  logic          uv_below_off_i,
   input  logic          uv_above_on_i,
   input  logic          fw_ready_i,
   input  logic          clear_i,
   input  logic          retry_mode_i,
   input  logic [CW-1:0] cooldown_cfg_i,
   input  logic [RW-1:0] retry_limit_i,
   input  logic [QW-1:0] quiet_cfg_i,
   output logic          force_safe_o,
   output logic [1:0]    state_o,
   output logic [RW-1:0] retry_cnt_o,
   output logic [2:0]    fault_code_o
);
   localparam int unsigned SLOW_W = 5;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("bridge_trip_ctrl: SYNC_STAGES must be at least 2");
   end
   if (CW < 1 || RW < 1 || QW < 1) begin : g_bad_width
      $error("bridge_trip_ctrl: counter widths must be at least 1");
   end

   logic [SLOW_W-1:0] slow_s;
   logic oc_s, ot_s, uvb_s, uva_s, rdy_s, desat_s;
   logic trip_s, uv_low_s, held_s;
   trip_state_t st_s;
   fault_code_t code_q;

   bridge_trip_sync #(.STAGES(SYNC_STAGES), .WIDTH(SLOW_W)) u_sync_slow (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({oc_flag_i, ot_flag_i, uv_below_off_i, uv_above_on_i, fw_ready_i}),
      .q_o   (slow_s)
   );
   assign {oc_s, ot_s, uvb_s, uva_s, rdy_s} = slow_s;

   if (DESAT_FAST) begin : g_desat_fast
      bridge_trip_sync #(.STAGES(1), .WIDTH(1)) u_sync_desat (
         .clk_i(clk_i), .rst_ni(rst_ni), .d_i(desat_flag_i), .q_o(desat_s)
      );
   end else begin : g_desat_slow
      bridge_trip_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_sync_desat (
         .clk_i(clk_i), .rst_ni(rst_ni), .d_i(desat_flag_i), .q_o(desat_s)
      );
   end

   assign trip_s = oc_s | ot_s | desat_s;

   bridge_trip_uvhyst u_uv (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .below_off_i (uvb_s),
      .above_on_i  (uva_s),
      .supply_low_o(uv_low_s)
   );

   bridge_trip_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ready_i(rdy_s),
      .held_o (held_s)
   );

   bridge_trip_policy #(.CW(CW), .RW(RW), .QW(QW)) u_policy (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .trip_i      (trip_s),
      .supply_low_i(uv_low_s),
      .held_i      (held_s),
      .clear_i     (clear_i),
      .retry_mode_i(retry_mode_i),
      .cooldown_i  (cooldown_cfg_i),
      .limit_i     (retry_limit_i),
      .quiet_i     (quiet_cfg_i),
      .state_o     (st_s),
      .retry_cnt_o (retry_cnt_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   code_q <= FC_NONE;
      else if (clear_i)              code_q <= FC_NONE;
      else if (code_q == FC_NONE) begin
         if (desat_s)                code_q <= FC_DESAT;
         else if (oc_s)              code_q <= FC_OC;
         else if (ot_s)              code_q <= FC_OT;
         else if (uvb_s && !uv_low_s) code_q <= FC_UV;
      end
   end

   assign force_safe_o = (st_s != ST_RUN) | trip_s | uv_low_s | uvb_s;
   assign state_o      = st_s;
   assign fault_code_o = code_q;
endmodule

// File: rtl/bridge_trip_chk.sv
module bridge_trip_chk #(
   parameter int unsigned RW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          force_safe,
   input logic [1:0]    state,
   input logic          trip,
   input logic          uv_low,
   input logic          clear,
   input logic          retry_mode,
   input logic [RW-1:0] rcnt,
   input logic [RW-1:0] limit,
   input logic [2:0]    code
);
   AST_TRIP_FORCES_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
      trip |-> force_safe); // R1
   AST_LATCH_STAYS_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd3 && !clear) |=> (state == 2'd3 && force_safe)); // R3
   AST_COOL_NO_REENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd2) |-> force_safe); // R5
   AST_RETRY_LIMIT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_mode && state == 2'd1 && trip && rcnt >= limit && !clear) |=> (state == 2'd3)); // R6
   AST_UV_LOW_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
      uv_low |-> force_safe); // R8
   AST_ARM_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd0) |-> force_safe); // R9
   AST_CODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (code != 3'd0 && !clear) |=> $stable(code)); // R10
endmodule

bind bridge_trip_ctrl bridge_trip_chk #(.RW(RW)) chk_i (
   .clk       (clk_i),
   .rst_n     (rst_ni),
   .force_safe(force_safe_o),
   .state     (state_o),
   .trip      (trip_s),
   .uv_low    (uv_low_s),
   .clear     (clear_i),
   .retry_mode(retry_mode_i),
   .rcnt      (retry_cnt_o),
   .limit     (retry_limit_i),
   .code      (fault_code_o)
);

// File: tb/bridge_trip_ctrl_tb_top.sv
`timescale 1ns/1ps
module bridge_trip_ctrl_tb_top;
   localparam int HOLD  = 8;
   localparam int COOL  = 5;
   localparam int LIM   = 2;
   localparam int QUIET = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic oc = 0, ot = 0, ds = 0, uvb = 0, uva = 0, rdy = 0, clr = 0, mode = 0;
   logic       fs;
   logic [1:0] st;
   logic [2:0] rc;
   logic [2:0] code;

   int total = 0, bad = 0;
   string tag = "R9";
   bit done = 0;

   always #4 clk = ~clk;

   bridge_trip_ctrl #(.SYNC_STAGES(2), .DESAT_FAST(1'b1), .HOLD_CYCLES(HOLD),
                      .CW(8), .RW(3), .QW(10)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .oc_flag_i(oc), .ot_flag_i(ot), .desat_flag_i(ds),
      .uv_below_off_i(uvb), .uv_above_on_i(uva), .fw_ready_i(rdy), .clear_i(clr),
      .retry_mode_i(mode), .cooldown_cfg_i(8'(COOL)), .retry_limit_i(3'(LIM)),
      .quiet_cfg_i(10'(QUIET)), .force_safe_o(fs), .state_o(st), .retry_cnt_o(rc),
      .fault_code_o(code)
   );

   // behavioural reference model
   bit [1:0] m_oc = 0, m_ot = 0, m_uvb = 0, m_uva = 0, m_rdy = 0;
   bit m_ds = 0, m_uvl = 1;
   int m_st = 0, m_rc = 0, m_qc = 0, m_cc = 0, m_hc = 0, m_code = 0;

   function automatic bit m_trip();
      return m_oc[1] | m_ot[1] | m_ds;
   endfunction
   function automatic bit m_fs();
      return (m_st != 1) || m_trip() || m_uvl || m_uvb[1];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_oc = 0; m_ot = 0; m_uvb = 0; m_uva = 0; m_rdy = 0; m_ds = 0; m_uvl = 1;
         m_st = 0; m_rc = 0; m_qc = 0; m_cc = 0; m_hc = 0; m_code = 0;
      end else begin
         bit tr;
         int nst, nrc, nqc, ncc, nhc, ncode;
         bit nuvl;
         tr = m_trip();
         nst = m_st; nrc = m_rc; nqc = 0; ncc = m_cc; ncode = m_code;
         nuvl = m_uvb[1] ? 1'b1 : (m_uva[1] ? 1'b0 : m_uvl);
         nhc = m_rdy[1] ? ((m_hc == HOLD) ? HOLD : m_hc + 1) : 0;
         if (clr) ncode = 0;
         else if (m_code == 0) begin
            if (m_ds) ncode = 4;
            else if (m_oc[1]) ncode = 2;
            else if (m_ot[1]) ncode = 3;
            else if (m_uvb[1] && !m_uvl) ncode = 1;
         end
         case (m_st)
            0: if (m_hc == HOLD && !tr && !m_uvl) nst = 1;
            1: begin
               if (tr) begin
                  if (!mode || m_rc >= LIM) nst = 3;
                  else begin nst = 2; ncc = 0; nrc = m_rc + 1; end
               end else if (m_qc == QUIET) nrc = 0;
               else nqc = m_qc + 1;
            end
            2: begin
               if (m_cc == COOL) begin if (!tr) nst = 1; end
               else ncc = m_cc + 1;
            end
            default: if (clr && !tr) nst = 1;
         endcase
         if (clr) nrc = 0;
         m_st = nst; m_rc = nrc; m_qc = nqc; m_cc = ncc; m_hc = nhc;
         m_code = ncode; m_uvl = nuvl;
         m_oc = {m_oc[0], oc}; m_ot = {m_ot[0], ot}; m_uvb = {m_uvb[0], uvb};
         m_uva = {m_uva[0], uva}; m_rdy = {m_rdy[0], rdy}; m_ds = ds;
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         total++;
         if (fs !== m_fs() || int'(st) != m_st || int'(rc) != m_rc || int'(code) != m_code) begin
            bad++;
            $display("FAIL %s model: fs=%0b st=%0d rc=%0d code=%0d expected fs=%0b st=%0d rc=%0d code=%0d",
                     tag, fs, st, rc, code, m_fs(), m_st, m_rc, m_code);
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_clear();
      @(negedge clk); clr = 1;
      @(negedge clk); clr = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      cyc(3);
      // R9 reset state
      chk("R9", int'(st), 0); chk("R9", int'(fs), 1); chk("R9", int'(code), 0);
      rst_n = 1;
      cyc(2);
      tag = "R9";
      rdy = 1; uva = 1;
      cyc(5);
      rdy = 0;
      cyc(1);
      rdy = 1;
      cyc(5);
      chk("R9", int'(st), 0);
      cyc(10);
      chk("R9", int'(st), 1); chk("R9", int'(fs), 0);

      // R1 latency, R3 latch, R10 code
      tag = "R1"; mode = 0;
      oc = 1;
      cyc(1); chk("R1", int'(fs), 0);
      oc = 0;
      cyc(1); chk("R1", int'(fs), 1);
      tag = "R3";
      cyc(6);
      chk("R3", int'(st), 3); chk("R3", int'(fs), 1); chk("R10", int'(code), 2);
      pulse_clear();
      chk("R3", int'(st), 1); chk("R10", int'(code), 0);

      // R2 desaturation short path
      tag = "R2";
      ds = 1;
      cyc(1); chk("R2", int'(fs), 1);
      ds = 0;
      cyc(4); chk("R10", int'(code), 4);
      pulse_clear();

      // R4 auto retry, R6 limit
      tag = "R4"; mode = 1;
      cyc(2);
      ot = 1; cyc(1); ot = 0;
      cyc(4); chk("R4", int'(st), 2); chk("R4", int'(rc), 1);
      cyc(8); chk("R4", int'(st), 1);
      ot = 1; cyc(1); ot = 0;
      cyc(12); chk("R4", int'(rc), 2);
      tag = "R6";
      ot = 1; cyc(1); ot = 0;
      cyc(6); chk("R6", int'(st), 3);
      pulse_clear();
      chk("R7", int'(rc), 0);

      // R7 quiet interval forgets retries
      tag = "R7";
      oc = 1; cyc(1); oc = 0;
      cyc(40); chk("R7", int'(rc), 0);
      oc = 1; cyc(1); oc = 0;
      cyc(12);
      oc = 1; cyc(1); oc = 0;
      cyc(4); chk("R7", int'(st), 2);
      cyc(12);

      // R5 fault outlives the cooldown
      tag = "R5";
      pulse_clear();
      oc = 1;
      cyc(15); chk("R5", int'(st), 2); chk("R5", int'(fs), 1);
      cyc(5); oc = 0;
      cyc(8); chk("R5", int'(st), 1); chk("R5", int'(fs), 0);

      // R8 undervoltage hysteresis
      tag = "R8";
      pulse_clear();
      uva = 0; uvb = 1;
      cyc(3); uvb = 0;
      cyc(10);
      chk("R8", int'(fs), 1); chk("R8", int'(st), 1); chk("R10", int'(code), 1);
      uva = 1;
      cyc(4); chk("R8", int'(fs), 0);

      tag = "R10";
      ot = 1; cyc(1); ot = 0;
      cyc(12); chk("R10", int'(code), 1);

      cyc(2);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule